// File: doc/BRIEF.md
# JTAG Indexed Register Access Port

This block lets a debug probe read and write a bank of 32-bit internal registers using only the data-register path of a JTAG test access port. The TAP controller sits outside and supplies the Capture-DR, Shift-DR and Update-DR strobes along with TCK. TDI comes in and TDO goes out. Every transfer needs two data-register scans. The first is a short selection scan that carries a 7-bit register index and a direction flag. The second is a 32-bit data scan. It brings out the old contents of the chosen register and, on a write, stores the bits shifted in.

The index space has 128 entries. Writable registers occupy the lowest `REG_COUNT` indices. The top index holds a fixed, read-only identification word. The remaining indices are empty. A reset of the test logic clears the bank and returns the block to the selection phase.

Top module: `jtag_regbank_port`

## Requirements
- R1: While `trst_n` is low and just after it rises, the block is in the selection phase, `tdo` is 0 and every writable register holds 0.
- R2: The selection scan is 8 bits, shifted least significant bit first. Bit 7 is the direction flag (1 = write, 0 = read) and bits 6:0 are the index. The selection and direction are latched at Update-DR of that scan and held otherwise.
- R3: Capture-DR in the selection phase loads the selection currently latched, as {direction, index}, so the selection scan shifts it out on `tdo`.
- R4: Capture-DR in the data phase loads the selected register's value, and the following 32 shift cycles present it on `tdo` least significant bit first.
- R5: On a write, the 32 bits shifted in during the data scan are stored into the selected register at Update-DR, and the old value is what appears on `tdo`.
- R6: On a read, the bits shifted in during the data scan are discarded and the register keeps its value.
- R7: Each Update-DR toggles between the selection phase and the data phase. A low `trst_n` forces the selection phase.
- R8: An index from `REG_COUNT` to 126 reads as all zeros, and a write to it changes nothing.
- R9: Index 127 reads as the constant `ID_VALUE`, and a write to it changes nothing.
- R10: A write changes only the selected register. Every other register keeps its value.
- R11: In a cycle with neither Capture-DR nor Shift-DR, the shift register holds, so `tdo` does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock; all state changes on its rising edge |
| trst_n | input | 1 | Active-low asynchronous test-logic reset |
| capture_dr | input | 1 | TAP controller is in Capture-DR with this block's register selected |
| shift_dr | input | 1 | TAP controller is in Shift-DR with this block's register selected |
| update_dr | input | 1 | TAP controller is in Update-DR with this block's register selected |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, bit 0 of the shift register |

## Verification
Random accesses alternate between writes and reads. They are spread across writable indices, empty indices and the identification index, so a write that leaks into an empty slot or into the constant is told apart from a correct store. Each selection scan reads back the previous selection, which exposes a phase that has slipped out of step. Random idle gaps between capture and shift bits separate a shift register that holds from one that drifts. Directed cases cover a full sweep after reset, a reset in the middle of a sequence, and a write followed by a sweep of its neighbours.

// File: rtl/jrp_pkg.sv
`timescale 1ns/1ps
package jrp_pkg;

  localparam int IDX_W = 7;
  localparam int SEL_W = IDX_W + 1;

  typedef enum logic {
    PH_SELECT = 1'b0,
    PH_DATA   = 1'b1
  } phase_e;

  typedef struct packed {
    logic             wr;
    logic [IDX_W-1:0] idx;
  } sel_t;

  // Selection word layout: direction flag on top, index below.
  function automatic sel_t decode_select(input logic [SEL_W-1:0] raw);
    sel_t s;
    s.wr  = raw[SEL_W-1];
    s.idx = raw[IDX_W-1:0];
    return s;
  endfunction

  function automatic logic [SEL_W-1:0] encode_select(input sel_t s);
    return {s.wr, s.idx};
  endfunction

  // True when the index names a storage register.
  function automatic logic idx_writable(input logic [IDX_W-1:0] idx, input int count);
    return int'(idx) < count;
  endfunction

  function automatic phase_e next_phase(input phase_e p);
    return (p == PH_SELECT) ? PH_DATA : PH_SELECT;
  endfunction

endpackage

// File: rtl/jrp_shifter.sv
`timescale 1ns/1ps
module jrp_shifter
  import jrp_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              tck,
  input  logic              trst_n,
  input  logic              capture_dr,
  input  logic              shift_dr,
  input  logic              tdi,
  input  phase_e            phase,
  input  logic [DATA_W-1:0] cap_value,
  output logic [DATA_W-1:0] sr,
  output logic              tdo
);

  localparam int TOP_DATA = DATA_W - 1;
  localparam int TOP_SEL  = SEL_W - 1;

  logic [DATA_W-1:0] sr_q;

  // One shift step: move toward bit 0 and enter TDI at the scan's top bit.
  function automatic logic [DATA_W-1:0] shift_step(
    input logic [DATA_W-1:0] cur,
    input logic              bit_in,
    input phase_e            ph
  );
    logic [DATA_W-1:0] nxt;
    nxt = cur >> 1;
    if (ph == PH_SELECT) nxt[TOP_SEL] = bit_in;
    else                 nxt[TOP_DATA] = bit_in;
    return nxt;
  endfunction

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      sr_q <= '0;
    end else if (capture_dr) begin
      sr_q <= cap_value;
    end else if (shift_dr) begin
      sr_q <= shift_step(sr_q, tdi, phase);
    end
  end

  assign sr  = sr_q;
  assign tdo = sr_q[0];

endmodule

// File: rtl/jrp_sequencer.sv
`timescale 1ns/1ps
module jrp_sequencer
  import jrp_pkg::*;
(
  input  logic             tck,
  input  logic             trst_n,
  input  logic             update_dr,
  input  logic [SEL_W-1:0] sel_bits,
  output phase_e           phase,
  output sel_t             sel,
  output logic             commit
);

  phase_e phase_q;
  sel_t   sel_q;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      phase_q <= PH_SELECT;
      sel_q   <= '0;
    end else if (update_dr) begin
      if (phase_q == PH_SELECT) sel_q <= decode_select(sel_bits);
      phase_q <= next_phase(phase_q);
    end
  end

  assign phase  = phase_q;
  assign sel    = sel_q;
  assign commit = update_dr && (phase_q == PH_DATA) && sel_q.wr;

endmodule

// File: rtl/jrp_regbank.sv
`timescale 1ns/1ps
module jrp_regbank
  import jrp_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          REG_COUNT = 16,
  parameter int          ID_INDEX  = 127,
  parameter logic [31:0] ID_VALUE  = 32'h5EED_C0DE
) (
  input  logic                 tck,
  input  logic                 trst_n,
  input  logic [IDX_W-1:0]     rd_idx,
  input  logic                 wr_en,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [DATA_W-1:0]    rd_data,
  output logic [REG_COUNT-1:0] wr_vec
);

  localparam logic [IDX_W-1:0]  ID_IDX = IDX_W'(ID_INDEX);
  localparam logic [DATA_W-1:0] ID_WORD = DATA_W'(ID_VALUE);

  logic [REG_COUNT-1:0][DATA_W-1:0] slot;

  for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign wr_vec[g] = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge tck or negedge trst_n) begin
      if (!trst_n)        q <= '0;
      else if (wr_vec[g]) q <= wr_data;
    end
    assign slot[g] = q;
  end

  always_comb begin
    rd_data = '0;
    if (idx_writable(rd_idx, REG_COUNT)) begin
      for (int i = 0; i < REG_COUNT; i++) begin
        if (rd_idx == IDX_W'(i)) rd_data = slot[i];
      end
    end else if (rd_idx == ID_IDX) begin
      rd_data = ID_WORD;
    end
  end

endmodule

// File: rtl/jtag_regbank_port.sv
`timescale 1ns/1ps
module jtag_regbank_port
  import jrp_pkg::*;
#(
  parameter int          DATA_W    = 32,
  parameter int          REG_COUNT = 16,
  parameter int          ID_INDEX  = 127,
  parameter logic [31:0] ID_VALUE  = 32'h5EED_C0DE
) (
  input  logic tck,
  input  logic trst_n,
  input  logic capture_dr,
  input  logic shift_dr,
  input  logic update_dr,
  input  logic tdi,
  output logic tdo
);

  phase_e                phase_w;
  sel_t                  sel_w;
  logic                  commit_w;
  logic [DATA_W-1:0]     sr_w;
  logic [DATA_W-1:0]     rd_data_w;
  logic [DATA_W-1:0]     cap_w;
  logic [REG_COUNT-1:0]  wr_vec_w;
  logic                  phase_bit_w;
  logic                  sel_wr_w;
  logic [IDX_W-1:0]      sel_idx_w;

  assign phase_bit_w = (phase_w == PH_DATA);
  assign sel_wr_w    = sel_w.wr;
  assign sel_idx_w   = sel_w.idx;

  // Capture source: latched selection in the first scan, register data in the second.
  always_comb begin
    cap_w = '0;
    if (phase_w == PH_SELECT) cap_w[SEL_W-1:0] = encode_select(sel_w);
    else                      cap_w = rd_data_w;
  end

  jrp_sequencer u_seq (
    .tck      (tck),
    .trst_n   (trst_n),
    .update_dr(update_dr),
    .sel_bits (sr_w[SEL_W-1:0]),
    .phase    (phase_w),
    .sel      (sel_w),
    .commit   (commit_w)
  );

  jrp_shifter #(.DATA_W(DATA_W)) u_shift (
    .tck       (tck),
    .trst_n    (trst_n),
    .capture_dr(capture_dr),
    .shift_dr  (shift_dr),
    .tdi       (tdi),
    .phase     (phase_w),
    .cap_value (cap_w),
    .sr        (sr_w),
    .tdo       (tdo)
  );

  jrp_regbank #(
    .DATA_W   (DATA_W),
    .REG_COUNT(REG_COUNT),
    .ID_INDEX (ID_INDEX),
    .ID_VALUE (ID_VALUE)
  ) u_bank (
    .tck    (tck),
    .trst_n (trst_n),
    .rd_idx (sel_w.idx),
    .wr_en  (commit_w),
    .wr_idx (sel_w.idx),
    .wr_data(sr_w),
    .rd_data(rd_data_w),
    .wr_vec (wr_vec_w)
  );

endmodule

// File: rtl/jrp_checker.sv
`timescale 1ns/1ps
module jrp_checker #(
  parameter int          DATA_W    = 32,
  parameter int          REG_COUNT = 16,
  parameter int          ID_INDEX  = 127,
  parameter logic [31:0] ID_VALUE  = 32'h5EED_C0DE
) (
  input logic                 tck,
  input logic                 trst_n,
  input logic                 capture_dr,
  input logic                 shift_dr,
  input logic                 update_dr,
  input logic                 tdo,
  input logic                 phase_bit_w,
  input logic                 sel_wr_w,
  input logic [6:0]           sel_idx_w,
  input logic [DATA_W-1:0]    rd_data_w,
  input logic [REG_COUNT-1:0] wr_vec_w
);

  assert_phase_flip_R7: assert property (@(posedge tck) disable iff (!trst_n)
    update_dr |=> (phase_bit_w != $past(phase_bit_w)));

  assert_phase_hold_R7: assert property (@(posedge tck) disable iff (!trst_n)
    !update_dr |=> $stable(phase_bit_w));

  assert_sel_hold_R2: assert property (@(posedge tck) disable iff (!trst_n)
    !(update_dr && !phase_bit_w) |=> $stable({sel_wr_w, sel_idx_w}));

  assert_tdo_idle_R11: assert property (@(posedge tck) disable iff (!trst_n)
    (!capture_dr && !shift_dr) |=> $stable(tdo));

  assert_empty_zero_R8: assert property (@(posedge tck) disable iff (!trst_n)
    (int'(sel_idx_w) >= REG_COUNT && int'(sel_idx_w) != ID_INDEX) |-> (rd_data_w == '0));

  assert_id_const_R9: assert property (@(posedge tck) disable iff (!trst_n)
    (int'(sel_idx_w) == ID_INDEX) |-> (rd_data_w == DATA_W'(ID_VALUE)));

  assert_one_target_R10: assert property (@(posedge tck) disable iff (!trst_n)
    $onehot0(wr_vec_w));

  assert_read_no_store_R6: assert property (@(posedge tck) disable iff (!trst_n)
    (!phase_bit_w || !sel_wr_w) |-> (wr_vec_w == '0));

endmodule

bind jtag_regbank_port jrp_checker #(
  .DATA_W   (DATA_W),
  .REG_COUNT(REG_COUNT),
  .ID_INDEX (ID_INDEX),
  .ID_VALUE (ID_VALUE)
) u_chk (
  .tck        (tck),
  .trst_n     (trst_n),
  .capture_dr (capture_dr),
  .shift_dr   (shift_dr),
  .update_dr  (update_dr),
  .tdo        (tdo),
  .phase_bit_w(phase_bit_w),
  .sel_wr_w   (sel_wr_w),
  .sel_idx_w  (sel_idx_w),
  .rd_data_w  (rd_data_w),
  .wr_vec_w   (wr_vec_w)
);

// File: tb/jtag_regbank_port_test.sv
`timescale 1ns/1ps
module jtag_regbank_port_test;

  localparam int          NREG  = 16;
  localparam logic [31:0] IDW   = 32'h5EED_C0DE;
  localparam int          IDIDX = 127;

  logic tck = 1'b0;
  logic trst_n = 1'b0;
  logic capture_dr = 1'b0;
  logic shift_dr = 1'b0;
  logic update_dr = 1'b0;
  logic tdi = 1'b0;
  logic tdo;

  int n_checks = 0;
  int n_fail = 0;

  logic [31:0] model [NREG];
  logic [7:0]  exp_sel;

  always #2.5 tck = ~tck;

  jtag_regbank_port #(.REG_COUNT(NREG), .ID_INDEX(IDIDX), .ID_VALUE(IDW)) uut (
    .tck(tck), .trst_n(trst_n), .capture_dr(capture_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .tdi(tdi), .tdo(tdo)
  );

  function automatic logic [31:0] expect_read(input logic [6:0] idx);
    if (int'(idx) < NREG) return model[int'(idx)];
    if (int'(idx) == IDIDX) return IDW;
    return 32'h0;
  endfunction

  function automatic string req_of(input logic [6:0] idx, input bit wr);
    if (int'(idx) == IDIDX) return "R9";
    if (int'(idx) >= NREG) return "R8";
    return wr ? "R5" : "R4";
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clear_model();
    for (int i = 0; i < NREG; i++) model[i] = 32'h0;
    exp_sel = 8'h00;
  endtask

  // One data-register pass: capture, n shifts (with idle gaps), update.
  task automatic do_scan(input int n, input logic [31:0] din, input int gap,
                         output logic [31:0] dout);
    dout = 32'h0;
    @(negedge tck); capture_dr = 1'b1;
    @(negedge tck); capture_dr = 1'b0;
    for (int i = 0; i < n; i++) begin
      for (int k = 0; k < gap; k++) begin
        logic held;
        held = tdo;
        tdi = ~tdi;
        @(negedge tck);
        check("R11", {31'h0, tdo}, {31'h0, held});
      end
      shift_dr = 1'b1; tdi = din[i]; dout[i] = tdo;
      @(negedge tck); shift_dr = 1'b0;
    end
    update_dr = 1'b1;
    @(negedge tck); update_dr = 1'b0;
  endtask

  task automatic access(input bit wr, input logic [6:0] idx, input logic [31:0] wd,
                        input int gap, input string req);
    logic [31:0] got;
    do_scan(8, {24'h0, wr, idx}, gap, got);
    check("R3", got, {24'h0, exp_sel});
    exp_sel = {wr, idx};
    do_scan(32, wd, gap, got);
    check(req, got, expect_read(idx));
    if (wr && int'(idx) < NREG) model[int'(idx)] = wd;
  endtask

  task automatic sweep(input string req);
    for (int i = 0; i < NREG; i++) access(1'b0, 7'(i), $urandom(), 0, req);
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_checks + 1, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd424242));
    clear_model();
    repeat (3) @(negedge tck);
    check("R1", {31'h0, tdo}, 32'h0);
    trst_n = 1'b1;
    @(negedge tck);
    check("R1", {31'h0, tdo}, 32'h0);
    sweep("R1");

    // R2 / R5: directed write and read-back on both ends of the writable range.
    access(1'b1, 7'd0, 32'hA5A5_0F0F, 0, "R5");
    access(1'b1, 7'(NREG - 1), 32'hFFFF_FFFF, 0, "R5");
    access(1'b0, 7'd0, 32'h1234_5678, 0, "R2");
    access(1'b0, 7'(NREG - 1), 32'h0, 1, "R6");
    // R8 / R9: writes to empty and constant indices leave them unchanged.
    access(1'b1, 7'(NREG), 32'hDEAD_BEEF, 0, "R8");
    access(1'b0, 7'(NREG), 32'h0, 0, "R8");
    access(1'b1, 7'd126, 32'hCAFE_F00D, 0, "R8");
    access(1'b0, 7'd126, 32'h0, 0, "R8");
    access(1'b1, 7'(IDIDX), 32'h0000_0001, 0, "R9");
    access(1'b0, 7'(IDIDX), 32'h0, 2, "R9");
    // R10: one write, then every neighbour is unchanged.
    access(1'b1, 7'd5, 32'h0BAD_F00D, 0, "R10");
    sweep("R10");

    // R7: reset in mid-sequence (after a selection scan) brings back the selection phase.
    begin
      logic [31:0] junk;
      do_scan(8, {24'h0, 1'b1, 7'd3}, 0, junk);
    end
    @(negedge tck); trst_n = 1'b0;
    @(negedge tck); trst_n = 1'b1;
    clear_model();
    @(negedge tck);
    check("R7", {31'h0, tdo}, 32'h0);
    access(1'b1, 7'd4, 32'h7777_AAAA, 0, "R7");
    access(1'b0, 7'd4, 32'h0, 0, "R7");

    // Random mix of indices, directions and idle gaps.
    for (int t = 0; t < 250; t++) begin
      logic [6:0] idx;
      int pick;
      bit wr;
      pick = int'($urandom_range(0, 9));
      if (pick < 6)      idx = 7'($urandom_range(0, NREG - 1));
      else if (pick < 8) idx = 7'($urandom_range(NREG, 126));
      else               idx = 7'(IDIDX);
      wr = bit'($urandom_range(0, 1));
      access(wr, idx, $urandom(), int'($urandom_range(0, 2)), req_of(idx, wr));
    end
    sweep("R6");

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule